// File: doc/BRIEF.md
# Timer Compare and Capture Unit

A 16-bit free-running timer peripheral for a small controller subsystem. A counter advances on every clock from zero after reset. It serves one output compare channel and one input capture channel. When the counter reaches the programmed compare value, the block sets a compare flag and loads the compare output pin with a level that software preset in the control register. A selected edge on the capture pin, after synchronisation, copies the counter into a capture register and sets a capture flag. Counter rollover sets an overflow flag.

Software reaches the block through a byte-wide register bus with an address, write and read strobes, and write and read data. The control register sits at the base address (0x12 by default). It holds three interrupt enables, a force bit that loads the compare pin at once, the capture edge select and the preset output level. A status register collects the three flags, which are cleared by writing ones. The interrupt line is high while any enabled flag is set.

Top module: `tcc_unit`

## Requirements
- R1: The counter is 0 during reset and increases by one on every clock edge afterwards. It wraps from 0xFFFF to 0x0000. Its high byte reads at base+6 (0x18) and its low byte at base+7 (0x19).
- R2: The compare value is written as a high byte at base+2 (0x14) and a low byte at base+3 (0x15), and it resets to 0x0000. The edge that ends a cycle in which the counter equals the compare value sets the compare flag, which is status bit 6.
- R3: That same edge loads the compare pin with the output level bit (control bit 0). The pin keeps its value on every other edge unless a force write occurs.
- R4: The control register at base+0 (0x12) reads back bits 7..5, 1 and 0 as written, and bits 4..2 always read 0. A write with bit 4 set loads the compare pin with the written bit 0 at that edge. Bit 3 has no effect on the pin.
- R5: Control bit 1 selects the capture edge: 1 for rising, 0 for falling. The pin passes two synchronising stages. A change driven while the counter shows N is captured as N+2, readable at base+4 (0x16, high) and base+5 (0x17, low), and sets status bit 7 on the third edge. The opposite edge captures nothing.
- R6: The edge on which the counter wraps from 0xFFFF sets the overflow flag, status bit 5.
- R7: Writing the status register (base+1, 0x13) clears each flag whose bit is written as 1. A 0 leaves the flag unchanged, and a set and a clear on the same edge leave the flag set.
- R8: The interrupt output is high exactly while some flag is set together with its enable: bit 7 for capture, bit 6 for compare, bit 5 for overflow.
- R9: Reset clears the counter, the flags, the compare pin, the output level bit and the enables. The capture edge select is not affected by reset.
- R10: A read outside the eight registers from base to base+7 returns 0x00, and read data is 0x00 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one edge per write |
| bus_rd | input | 1 | Read strobe, enables read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare output level latch |
| irq | output | 1 | Interrupt request |

## Verification
Reads are combinational, so the bench compares the counter bytes with its own cycle count in the same half cycle. Compare effects fall due one edge after the cycle where the counter equals the target, and control and status writes take effect on the edge that ends the write cycle. The bench therefore checks the flag and the pin both in the matching cycle and in the cycle after it, and it checks the overflow flag both at 0xFFFF and at 0x0000. For capture, the flag must still be clear two edges after the pin changes and must be set after the third, with the value equal to the count at the time the pin was driven plus two. The bench samples at each of these points to confirm the latency exactly.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   // register offsets from the base address
   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_STAT  = 3'd1,
      REG_CMP_H = 3'd2,
      REG_CMP_L = 3'd3,
      REG_CAP_H = 3'd4,
      REG_CAP_L = 3'd5,
      REG_CNT_H = 3'd6,
      REG_CNT_L = 3'd7
   } tcc_reg_e;

   localparam int NUM_REGS = 8;

   // control register bit positions
   localparam int B_LEVEL = 0;
   localparam int B_EDGE  = 1;
   localparam int B_FORCE = 4;

   // flag vector indices; status byte holds them in bits 7..5
   localparam int F_OVF = 0;
   localparam int F_CMP = 1;
   localparam int F_CAP = 2;
endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end

   // counter at all ones: next edge rolls over
   assign wrap_o = &cnt_o;
endmodule

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o =  sync_q[STAGES-1] & ~prev_q;
   assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/tcc_capture.sv
module tcc_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt_i,
   input  logic [W-1:0] cnt_i,
   output logic [W-1:0] cap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cap_o <= '0;
      else if (evt_i) cap_o <= cnt_i;
   end
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_i,
   input  logic         wr_hi_i,
   input  logic         wr_lo_i,
   input  logic [7:0]   wdata_i,
   input  logic         level_i,
   input  logic         force_i,
   input  logic         force_lvl_i,
   output logic [W-1:0] cmp_o,
   output logic         match_o,
   output logic         pin_o
);
   localparam int HI_W = W - 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_o <= '0;
      end else begin
         if (wr_lo_i) cmp_o[7:0]   <= wdata_i;
         if (wr_hi_i) cmp_o[W-1:8] <= wdata_i[HI_W-1:0];
      end
   end

   assign match_o = (cnt_i == cmp_o);

   // output level latch: a force write overrides a same-edge match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pin_o <= 1'b0;
      else if (force_i) pin_o <= force_lvl_i;
      else if (match_o) pin_o <= level_i;
   end
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
   import tcc_pkg::*;
#(
   parameter int         W           = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] BASE_ADDR   = 8'h12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       cap_pin,
   output logic       cmp_pin,
   output logic       irq
);
   generate
      if (W < 9 || W > 16) begin : g_bad_width
         $error("tcc_unit: W must lie in 9..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tcc_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [7:0]          ofs;
   logic                hit;
   tcc_reg_e            sel;
   logic [NUM_REGS-1:0] wr_sel;

   assign ofs = bus_addr - BASE_ADDR;
   assign hit = (ofs[7:3] == 5'd0);
   assign sel = tcc_reg_e'(ofs[2:0]);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign wr_sel[i] = bus_wr & hit & (sel == tcc_reg_e'(i));
   end

   // ---------------- control register ----------------
   logic [2:0] ie_q;      // {capture, compare, overflow}
   logic       level_q;
   logic       edge_q;
   logic       force_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q    <= '0;
         level_q <= 1'b0;
      end else if (wr_sel[REG_CTRL]) begin
         ie_q    <= bus_wdata[7:5];
         level_q <= bus_wdata[B_LEVEL];
      end
   end

   // edge select keeps its value through reset
   always_ff @(posedge clk) begin
      if (wr_sel[REG_CTRL]) edge_q <= bus_wdata[B_EDGE];
   end

   assign force_wr = wr_sel[REG_CTRL] & bus_wdata[B_FORCE];

   // ---------------- datapath ----------------
   logic [W-1:0] cnt_q;
   logic [W-1:0] cmp_q;
   logic [W-1:0] cap_q;
   logic         wrap;
   logic         match;
   logic         cap_rise;
   logic         cap_fall;
   logic         cap_evt;

   tcc_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_o  (cnt_q),
      .wrap_o (wrap)
   );

   tcc_compare #(.W(W)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_i       (cnt_q),
      .wr_hi_i     (wr_sel[REG_CMP_H]),
      .wr_lo_i     (wr_sel[REG_CMP_L]),
      .wdata_i     (bus_wdata),
      .level_i     (level_q),
      .force_i     (force_wr),
      .force_lvl_i (bus_wdata[B_LEVEL]),
      .cmp_o       (cmp_q),
      .match_o     (match),
      .pin_o       (cmp_pin)
   );

   tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin),
      .rise_o (cap_rise),
      .fall_o (cap_fall)
   );

   assign cap_evt = edge_q ? cap_rise : cap_fall;

   tcc_capture #(.W(W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (cap_evt),
      .cnt_i (cnt_q),
      .cap_o (cap_q)
   );

   // ---------------- flags and interrupt ----------------
   logic [2:0] flags_q;
   logic [2:0] flags_set;
   logic [2:0] flags_clr;

   always_comb begin
      flags_set        = '0;
      flags_set[F_CAP] = cap_evt;
      flags_set[F_CMP] = match;
      flags_set[F_OVF] = wrap;
   end

   assign flags_clr = wr_sel[REG_STAT] ? bus_wdata[7:5] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_set | (flags_q & ~flags_clr);
   end

   assign irq = |(flags_q & ie_q);

   // ---------------- read path ----------------
   logic [15:0] cmp_pad;
   logic [15:0] cap_pad;
   logic [15:0] cnt_pad;
   logic [7:0]  rd_byte;

   assign cmp_pad = 16'(cmp_q);
   assign cap_pad = 16'(cap_q);
   assign cnt_pad = 16'(cnt_q);

   always_comb begin
      case (sel)
         REG_CTRL:  rd_byte = {ie_q, 3'b000, edge_q, level_q};
         REG_STAT:  rd_byte = {flags_q, 5'b00000};
         REG_CMP_H: rd_byte = cmp_pad[15:8];
         REG_CMP_L: rd_byte = cmp_pad[7:0];
         REG_CAP_H: rd_byte = cap_pad[15:8];
         REG_CAP_L: rd_byte = cap_pad[7:0];
         REG_CNT_H: rd_byte = cnt_pad[15:8];
         REG_CNT_L: rd_byte = cnt_pad[7:0];
         default:   rd_byte = 8'h00;
      endcase
   end

   assign bus_rdata = (bus_rd && hit) ? rd_byte : 8'h00;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
   parameter int         W         = 16,
   parameter logic [7:0] BASE_ADDR = 8'h12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_wr,
   input logic [7:0]   bus_addr,
   input logic         frc_bit,
   input logic         lvl_bit,
   input logic [W-1:0] cnt,
   input logic [W-1:0] cmp_val,
   input logic [W-1:0] cap_val,
   input logic         cap_evt,
   input logic         level,
   input logic [2:0]   ie,
   input logic [2:0]   flags,
   input logic         cmp_pin,
   input logic         irq
);
   logic ctrl_wr;
   logic force_wr;

   assign ctrl_wr  = bus_wr && (bus_addr == BASE_ADDR);
   assign force_wr = ctrl_wr && frc_bit;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> cnt == $past(cnt) + 1'b1);                                // R1

   AST_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == cmp_val) |=> flags[1]);                                     // R2

   AST_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == cmp_val && !force_wr) |=> cmp_pin == $past(level));         // R3

   AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != cmp_val && !force_wr) |=> $stable(cmp_pin));                // R3

   AST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      force_wr |=> cmp_pin == $past(lvl_bit));                            // R4

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_val == $past(cnt)) && flags[2]);                   // R5

   AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt) |=> flags[0] && cnt == '0);                                  // R6

   AST_OVF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cnt) && ie[0] && !ctrl_wr) |=> irq);                             // R8

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == 3'b000) |-> !irq);                                           // R8
endmodule

bind tcc_unit tcc_checker #(.W(W), .BASE_ADDR(BASE_ADDR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .frc_bit  (bus_wdata[4]),
   .lvl_bit  (bus_wdata[0]),
   .cnt      (cnt_q),
   .cmp_val  (cmp_q),
   .cap_val  (cap_q),
   .cap_evt  (cap_evt),
   .level    (level_q),
   .ie       (ie_q),
   .flags    (flags_q),
   .cmp_pin  (cmp_pin),
   .irq      (irq)
);

// File: tb/tcc_unit_test.sv
module tcc_unit_test;
   localparam logic [7:0] A_CTRL = 8'h12;
   localparam logic [7:0] A_STAT = 8'h13;
   localparam logic [7:0] A_CMPH = 8'h14;
   localparam logic [7:0] A_CMPL = 8'h15;
   localparam logic [7:0] A_CAPH = 8'h16;
   localparam logic [7:0] A_CAPL = 8'h17;
   localparam logic [7:0] A_CNTH = 8'h18;
   localparam logic [7:0] A_CNTL = 8'h19;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_addr;
   logic       bus_wr;
   logic       bus_rd;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       cap_pin;
   logic       cmp_pin;
   logic       irq;

   always #5 clk = ~clk;

   tcc_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cap_pin   (cap_pin),
      .cmp_pin   (cmp_pin),
      .irq       (irq)
   );

   // bench time base: edges since reset release
   logic [15:0] bc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bc <= '0;
      else        bc <= bc + 16'd1;
   end

   int checks = 0;
   int fails  = 0;
   logic [7:0]  ctrl_sh;
   logic        exp_pin;
   logic [7:0]  rv;
   logic [15:0] r16;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      d        = bus_rdata;
      bus_rd   = 1'b0;
   endtask

   task automatic rd16(input logic [7:0] ah, output logic [15:0] v);
      logic [7:0] h;
      logic [7:0] l;
      rd(ah, h);
      rd(ah + 8'd1, l);
      v = {h, l};
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] t;
      logic [15:0] n;
      logic [15:0] old_cap;
      logic        lvl;
      logic        es;
      logic        newp;
      logic        hit_edge;

      rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
      bus_wdata = 8'h00; cap_pin = 1'b0;
      repeat (3) @(negedge clk);

      // reset state
      rd(A_CTRL, rv); chk("R9 ctrl at reset (edge bit masked)", rv & 8'hFD, 8'h00);
      rd(A_STAT, rv); chk("R9 flags at reset", rv, 8'h00);
      rd16(A_CNTH, r16); chk("R9 counter at reset", r16, 16'h0000);
      chk("R9 pin at reset", cmp_pin, 1'b0);
      chk("R9 irq at reset", irq, 1'b0);
      exp_pin = 1'b0;

      @(negedge clk) rst_n = 1'b1;
      repeat (5) @(negedge clk);
      rd16(A_CNTH, r16); chk("R1 counter follows edges", r16, bc);
      wr(A_STAT, 8'hE0);

      // unmapped addresses and idle strobe
      rd(8'h00, rv); chk("R10 read below window", rv, 8'h00);
      rd(8'h11, rv); chk("R10 read just below base", rv, 8'h00);
      rd(8'h1A, rv); chk("R10 read just above window", rv, 8'h00);
      bus_addr = A_CNTL; #1; chk("R10 no strobe gives zero", bus_rdata, 8'h00);

      // move compare far away, then sweep every control value
      t = bc + 16'd6000;
      wr(A_CMPL, t[7:0]);
      wr(A_CMPH, t[15:8]);
      for (int v = 0; v < 256; v++) begin
         wr(A_CTRL, 8'(v));
         if (v[4]) exp_pin = v[0];
         rd(A_CTRL, rv);
         chk("R4 control readback", rv, 8'(v) & 8'hE3);
         chk("R4 force and bit 3 on pin", cmp_pin, exp_pin);
      end
      ctrl_sh = 8'h00;
      wr(A_CTRL, ctrl_sh);
      rd16(A_CMPH, r16); chk("R2 compare readback", r16, t);
      rd16(A_CNTH, r16); chk("R1 counter after sweep", r16, bc);

      // compare sweep with alternating preset levels
      for (int k = 0; k < 8; k++) begin
         lvl     = k[0];
         ctrl_sh = {ctrl_sh[7:1], lvl};
         wr(A_CTRL, ctrl_sh);
         wr(A_STAT, 8'h40);
         t = bc + 16'd10 + 16'(7 * k);
         wr(A_CMPL, t[7:0]);
         wr(A_CMPH, t[15:8]);
         while (bc != t) @(negedge clk);
         rd(A_STAT, rv); chk("R2 flag clear in matching cycle", rv[6], 1'b0);
         chk("R3 pin unchanged before match edge", cmp_pin, exp_pin);
         @(negedge clk);
         rd(A_STAT, rv); chk("R2 flag set after match edge", rv[6], 1'b1);
         chk("R3 pin takes preset level", cmp_pin, lvl);
         exp_pin = lvl;
         repeat (3) @(negedge clk);
         chk("R3 pin holds without match", cmp_pin, exp_pin);
      end

      // interrupt gating on the compare flag
      chk("R8 irq low with enables off", irq, 1'b0);
      ctrl_sh[6] = 1'b1; wr(A_CTRL, ctrl_sh);
      chk("R8 irq high with compare enable", irq, 1'b1);
      ctrl_sh[6] = 1'b0; ctrl_sh[7] = 1'b1; wr(A_CTRL, ctrl_sh);
      rd(A_STAT, rv);
      chk("R8 irq follows capture enable and flag", irq, rv[7]);
      ctrl_sh[7] = 1'b0; wr(A_CTRL, ctrl_sh);

      // clear behaviour
      wr(A_STAT, 8'h40);
      rd(A_STAT, rv); chk("R7 one clears compare flag", rv[6], 1'b0);
      t = bc + 16'd8;
      wr(A_CMPL, t[7:0]);
      wr(A_CMPH, t[15:8]);
      while (bc != t) @(negedge clk);
      wr(A_STAT, 8'h40);
      rd(A_STAT, rv); chk("R7 set beats same-edge clear", rv[6], 1'b1);
      wr(A_STAT, 8'h00);
      rd(A_STAT, rv); chk("R7 zero write leaves flag", rv[6], 1'b1);
      wr(A_STAT, 8'h40);
      rd(A_STAT, rv); chk("R7 later clear works", rv[6], 1'b0);

      // capture sweep over both edge selects and both pin directions
      for (int k = 0; k < 8; k++) begin
         es = k[1];
         if (ctrl_sh[1] != es) begin
            ctrl_sh[1] = es;
            wr(A_CTRL, ctrl_sh);
         end
         wr(A_STAT, 8'h80);
         rd16(A_CAPH, old_cap);
         newp     = ~cap_pin;
         hit_edge = es ? newp : ~newp;
         n        = bc;
         cap_pin  = newp;
         repeat (2) @(negedge clk);
         rd(A_STAT, rv); chk("R5 capture flag not yet set", rv[7], 1'b0);
         @(negedge clk);
         rd(A_STAT, rv); chk("R5 capture flag on selected edge only", rv[7], hit_edge);
         rd16(A_CAPH, r16);
         chk("R5 captured count", r16, hit_edge ? n + 16'd2 : old_cap);
         repeat (k + 1) @(negedge clk);
      end

      // overflow
      ctrl_sh[7:5] = 3'b001;
      wr(A_CTRL, ctrl_sh);
      rd(A_STAT, rv); chk("R6 no overflow before wrap", rv[5], 1'b0);
      while (bc != 16'hFFFF) @(negedge clk);
      rd(A_STAT, rv); chk("R6 overflow clear at all ones", rv[5], 1'b0);
      chk("R8 irq low before wrap", irq, 1'b0);
      @(negedge clk);
      rd(A_STAT, rv); chk("R6 overflow set on wrap", rv[5], 1'b1);
      chk("R8 irq from overflow", irq, 1'b1);
      rd16(A_CNTH, r16); chk("R1 counter wrapped to zero", r16, 16'h0000);
      wr(A_STAT, 8'h20);
      rd(A_STAT, rv); chk("R7 overflow cleared", rv[5], 1'b0);
      chk("R8 irq drops after clear", irq, 1'b0);

      summary();
      $finish;
   end
endmodule